// File: doc/BRIEF.md
# Timed Power-Mode Controller

This block sequences a processor between three operating modes: full operation, a clock-stopped standby in which the logic keeps its supply, and a deep low-power state in which the domain supply is removed. Software or a wake source raises single-cycle requests. The controller then drives the CPU clock gate and the domain supply enable, and it raises a busy flag for as long as a mode change is in progress. A free-running timer strobe `tick` measures every change. Each kind of change has its own latency, given as a parameter in ticks. The defaults assume one tick per millisecond: 10 ticks from full operation into standby and 10 back, and 160 ticks to wake from the deep state. Entry into the deep state is always done as three equal steps of 30 ticks each, and an output shows which step is active.

The controller also keeps a running energy figure. On every tick it adds the power weight of the mode it is reporting at that moment, which includes the ticks spent inside a transition, so the cost of changing modes is counted. The default weights use units of 0.01 mW: 40000 in full operation, 5000 in standby and 16 in the deep state. The accumulator holds at its all-ones value once it saturates. All latencies, weights and the accumulator width are parameters, so a bench can use small values.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `mode` is 0 (run), `cpu_clk_en` and `pwr_en` are 1, `busy` is 0, `sleep_phase` is 0 and `energy` is 0.
- R2: `mode` encodes run as 0, idle as 1 and sleep as 2. `cpu_clk_en` is 1 exactly while `mode` is run. `pwr_en` is 0 only while the block is settled in sleep.
- R3: An accepted request sets `busy` in the next cycle. `mode` keeps its old value until the final tick of the transition and changes at that tick, when `busy` also drops. Run to idle takes T_RUN_IDLE ticks, idle to run takes T_IDLE_RUN ticks and sleep to run takes T_SLEEP_RUN ticks.
- R4: Sleep entry, from run or from idle, runs three steps of T_STEP ticks each. `sleep_phase` is one-hot during the entry: bit 0 for the first step, bit 1 for the second and bit 2 for the third. `mode` becomes sleep after 3*T_STEP ticks.
- R5: While `busy` is 1, `req_idle`, `req_sleep` and `wake` are ignored. This includes a repeated sleep request during sleep entry.
- R6: In run, a sleep request wins over an idle request and `wake` is ignored. In idle, `wake` wins over a sleep request and `req_idle` is ignored. In sleep, only `wake` is accepted.
- R7: When `wake` is accepted in sleep, `pwr_en` rises in the next cycle. `cpu_clk_en` stays 0 until the wake completes.
- R8: On each cycle with `tick` high, `energy` increases by the weight of the mode shown on `mode` in that cycle. On a cycle without `tick`, `energy` does not change.
- R9: `energy` saturates at 2^EW-1 and never decreases.
- R10: Only cycles with `tick` high advance a transition. Cycles without a tick leave `busy`, `mode` and `sleep_phase` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timer strobe, one pulse per time unit |
| req_idle | input | 1 | Request to enter idle |
| req_sleep | input | 1 | Request to enter sleep |
| wake | input | 1 | Wake event, returns to run |
| mode | output | 2 | Current mode: 0 run, 1 idle, 2 sleep |
| cpu_clk_en | output | 1 | CPU clock enable |
| pwr_en | output | 1 | Power-domain supply enable |
| busy | output | 1 | Transition in progress |
| sleep_phase | output | 3 | One-hot active sleep-entry step |
| energy | output | EW | Saturating energy accumulator |

## Verification
The assertions assume that `tick`, the requests and `wake` are clean synchronous levels sampled at the clock edge, and that reset is held for at least one full cycle. They also assume every latency parameter is at least 1, so a transition never finishes in the cycle that accepts it. The bench changes inputs only on the falling edge and keeps requests to one cycle, with or without a tick. It holds reset for several cycles before it releases it. It uses latencies of 2, 3, 2 and 4 ticks, which lets it check every tick of every transition.

// File: rtl/pwr_mode_pkg.sv
// Shared types for the power-mode controller.
// Assumes: exactly three sleep-entry steps; mode codes are visible at the top port.
package pwr_mode_pkg;

    // Reported operating mode (codes are part of the port contract)
    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_SLEEP = 2'd2
    } pm_mode_e;

    // Transition currently in flight
    typedef enum logic [1:0] {
        TR_NONE  = 2'd0,
        TR_IDLE  = 2'd1,
        TR_RUN   = 2'd2,
        TR_SLEEP = 2'd3
    } pm_trans_e;

    localparam int SLEEP_STEPS = 3;

endpackage

// File: rtl/pm_tick_timer.sv
// Down-counter measured in timer ticks.
// A load arms it with a count of ticks. It signals expire on the tick that
// brings the count from 1 to 0. Load takes priority over counting.
// Assumes: load_val >= 1.
module pm_tick_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);

    logic [CW-1:0] cnt_q;

    // Count remaining ticks of the current interval
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Final tick of an armed interval
    assign expire = tick && (cnt_q == CW'(1));

endmodule

// File: rtl/pm_mode_fsm.sv
// Mode and transition state machine.
// Accepts requests only while no transition is in flight, loads the tick
// timer with the latency of the chosen transition, steps through the three
// sleep-entry phases, and updates the mode only when the last interval expires.
// Assumes: all latency parameters >= 1.
module pm_mode_fsm
    import pwr_mode_pkg::*;
#(
    parameter int T_RUN_IDLE  = 10,
    parameter int T_IDLE_RUN  = 10,
    parameter int T_STEP      = 30,
    parameter int T_SLEEP_RUN = 160
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   req_idle,
    input  logic                   req_sleep,
    input  logic                   wake,
    output pm_mode_e               mode_o,
    output logic                   busy_o,
    output logic [SLEEP_STEPS-1:0] phase_o,
    output logic                   pwr_en_o,
    output logic                   clk_en_o
);

    localparam int LMAX_A = (T_RUN_IDLE > T_IDLE_RUN) ? T_RUN_IDLE : T_IDLE_RUN;
    localparam int LMAX_B = (T_STEP > T_SLEEP_RUN) ? T_STEP : T_SLEEP_RUN;
    localparam int LMAX   = (LMAX_A > LMAX_B) ? LMAX_A : LMAX_B;
    localparam int CW     = $clog2(LMAX + 1);
    localparam int STEP_W = $clog2(SLEEP_STEPS);

    localparam logic [CW-1:0]     LV_RI   = CW'(T_RUN_IDLE);
    localparam logic [CW-1:0]     LV_IR   = CW'(T_IDLE_RUN);
    localparam logic [CW-1:0]     LV_STEP = CW'(T_STEP);
    localparam logic [CW-1:0]     LV_SR   = CW'(T_SLEEP_RUN);
    localparam logic [STEP_W-1:0] LAST_ST = STEP_W'(SLEEP_STEPS - 1);

    pm_mode_e            mode_q, mode_d;
    pm_trans_e           trans_q, trans_d;
    logic [STEP_W-1:0]   step_q, step_d;
    logic                tmr_load;
    logic [CW-1:0]       tmr_val;
    logic                tmr_expire;

    pm_tick_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    // Next-state: accept requests when settled, advance or finish when timer expires
    always_comb begin
        mode_d   = mode_q;
        trans_d  = trans_q;
        step_d   = step_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (trans_q == TR_NONE) begin
            case (mode_q)
                PM_RUN: begin
                    if (req_sleep) begin
                        trans_d  = TR_SLEEP;
                        step_d   = '0;
                        tmr_load = 1'b1;
                        tmr_val  = LV_STEP;
                    end else if (req_idle) begin
                        trans_d  = TR_IDLE;
                        tmr_load = 1'b1;
                        tmr_val  = LV_RI;
                    end
                end
                PM_IDLE: begin
                    if (wake) begin
                        trans_d  = TR_RUN;
                        tmr_load = 1'b1;
                        tmr_val  = LV_IR;
                    end else if (req_sleep) begin
                        trans_d  = TR_SLEEP;
                        step_d   = '0;
                        tmr_load = 1'b1;
                        tmr_val  = LV_STEP;
                    end
                end
                PM_SLEEP: begin
                    if (wake) begin
                        trans_d  = TR_RUN;
                        tmr_load = 1'b1;
                        tmr_val  = LV_SR;
                    end
                end
                default: ;
            endcase
        end else if (tmr_expire) begin
            if ((trans_q == TR_SLEEP) && (step_q != LAST_ST)) begin
                step_d   = step_q + 1'b1;
                tmr_load = 1'b1;
                tmr_val  = LV_STEP;
            end else begin
                trans_d = TR_NONE;
                step_d  = '0;
                case (trans_q)
                    TR_IDLE:  mode_d = PM_IDLE;
                    TR_RUN:   mode_d = PM_RUN;
                    TR_SLEEP: mode_d = PM_SLEEP;
                    default:  mode_d = mode_q;
                endcase
            end
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= PM_RUN;
            trans_q <= TR_NONE;
            step_q  <= '0;
        end else begin
            mode_q  <= mode_d;
            trans_q <= trans_d;
            step_q  <= step_d;
        end
    end

    // One-hot phase indicator, one bit per sleep-entry step
    for (genvar g = 0; g < SLEEP_STEPS; g++) begin : g_phase
        assign phase_o[g] = (trans_q == TR_SLEEP) && (step_q == STEP_W'(g));
    end

    assign mode_o   = mode_q;
    assign busy_o   = (trans_q != TR_NONE);
    assign clk_en_o = (mode_q == PM_RUN);
    assign pwr_en_o = !((mode_q == PM_SLEEP) && (trans_q == TR_NONE));

endmodule

// File: rtl/pm_energy_acc.sv
// Saturating energy accumulator.
// On every tick it adds the power weight of the mode currently reported.
// Assumes: each weight fits in EW bits.
module pm_energy_acc
    import pwr_mode_pkg::*;
#(
    parameter int EW      = 40,
    parameter int W_RUN   = 40000,
    parameter int W_IDLE  = 5000,
    parameter int W_SLEEP = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  pm_mode_e      mode_i,
    output logic [EW-1:0] energy_o
);

    localparam logic [EW-1:0] WV_RUN   = EW'(W_RUN);
    localparam logic [EW-1:0] WV_IDLE  = EW'(W_IDLE);
    localparam logic [EW-1:0] WV_SLEEP = EW'(W_SLEEP);

    logic [EW-1:0] acc_q;
    logic [EW-1:0] weight;
    logic [EW:0]   sum;

    // Select the weight of the reported mode
    always_comb begin
        case (mode_i)
            PM_RUN:   weight = WV_RUN;
            PM_IDLE:  weight = WV_IDLE;
            PM_SLEEP: weight = WV_SLEEP;
            default:  weight = '0;
        endcase
    end

    assign sum = {1'b0, acc_q} + {1'b0, weight};

    // Accumulate on tick, clamping at all-ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (tick) begin
            acc_q <= sum[EW] ? '1 : sum[EW-1:0];
        end
    end

    assign energy_o = acc_q;

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Top level of the timed power-mode controller.
// Ties together the mode state machine (with its tick timer) and the
// per-mode energy accumulator.
// Assumes: tick and requests are synchronous to clk.
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int T_RUN_IDLE  = 10,
    parameter int T_IDLE_RUN  = 10,
    parameter int T_STEP      = 30,
    parameter int T_SLEEP_RUN = 160,
    parameter int EW          = 40,
    parameter int W_RUN       = 40000,
    parameter int W_IDLE      = 5000,
    parameter int W_SLEEP     = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          req_idle,
    input  logic          req_sleep,
    input  logic          wake,
    output logic [1:0]    mode,
    output logic          cpu_clk_en,
    output logic          pwr_en,
    output logic          busy,
    output logic [2:0]    sleep_phase,
    output logic [EW-1:0] energy
);

    pm_mode_e mode_s;

    pm_mode_fsm #(
        .T_RUN_IDLE  (T_RUN_IDLE),
        .T_IDLE_RUN  (T_IDLE_RUN),
        .T_STEP      (T_STEP),
        .T_SLEEP_RUN (T_SLEEP_RUN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .req_idle  (req_idle),
        .req_sleep (req_sleep),
        .wake      (wake),
        .mode_o    (mode_s),
        .busy_o    (busy),
        .phase_o   (sleep_phase),
        .pwr_en_o  (pwr_en),
        .clk_en_o  (cpu_clk_en)
    );

    pm_energy_acc #(
        .EW      (EW),
        .W_RUN   (W_RUN),
        .W_IDLE  (W_IDLE),
        .W_SLEEP (W_SLEEP)
    ) u_energy (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode_i   (mode_s),
        .energy_o (energy)
    );

    assign mode = mode_s;

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
// Port-level checker for the power-mode controller, bound to the top.
// Assumes: reset is held for at least one cycle before checking starts.
module pwr_mode_ctrl_chk #(
    parameter int EW = 40
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          req_idle,
    input logic          req_sleep,
    input logic          wake,
    input logic [1:0]    mode,
    input logic          cpu_clk_en,
    input logic          pwr_en,
    input logic          busy,
    input logic [2:0]    sleep_phase,
    input logic [EW-1:0] energy
);

    logic seen_q;

    // Marks that one full cycle out of reset has elapsed
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R3
    mode_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && (mode != $past(mode)) |-> $past(busy) && $past(tick));

    // R10
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(busy) && !$past(tick) |-> busy && $stable(mode) && $stable(sleep_phase));

    // R8
    energy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && !$past(tick) |-> $stable(energy));

    // R9
    energy_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> energy >= $past(energy));

    // R4
    phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sleep_phase));

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $rose(busy) |-> $past(req_idle || req_sleep || wake));

    // R7
    pwr_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $rose(pwr_en) |-> busy && (mode == 2'd2) && !cpu_clk_en);

    // R2
    clk_needs_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> pwr_en);

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.EW(EW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .req_idle    (req_idle),
    .req_sleep   (req_sleep),
    .wake        (wake),
    .mode        (mode),
    .cpu_clk_en  (cpu_clk_en),
    .pwr_en      (pwr_en),
    .busy        (busy),
    .sleep_phase (sleep_phase),
    .energy      (energy)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;

    localparam int T_RI  = 2;
    localparam int T_IR  = 3;
    localparam int T_ST  = 2;
    localparam int T_SR  = 4;
    localparam int EW    = 10;
    localparam int WR    = 7;
    localparam int WI    = 3;
    localparam int WS    = 1;
    localparam int EMAX  = (1 << EW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          req_idle = 1'b0;
    logic          req_sleep = 1'b0;
    logic          wake = 1'b0;
    logic [1:0]    mode;
    logic          cpu_clk_en;
    logic          pwr_en;
    logic          busy;
    logic [2:0]    sleep_phase;
    logic [EW-1:0] energy;

    int n_chk = 0;
    int n_err = 0;
    int exp_e = 0;

    always #2 clk = ~clk;

    pwr_mode_ctrl #(
        .T_RUN_IDLE(T_RI), .T_IDLE_RUN(T_IR), .T_STEP(T_ST), .T_SLEEP_RUN(T_SR),
        .EW(EW), .W_RUN(WR), .W_IDLE(WI), .W_SLEEP(WS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .req_idle(req_idle),
        .req_sleep(req_sleep), .wake(wake), .mode(mode), .cpu_clk_en(cpu_clk_en),
        .pwr_en(pwr_en), .busy(busy), .sleep_phase(sleep_phase), .energy(energy)
    );

    task automatic chk(input string req, input string what, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Check all control outputs against an expected state
    task automatic chk_state(input string req, input int m, input int b, input int ph);
        chk(req, "mode", int'(mode), m);
        chk(req, "busy", int'(busy), b);
        chk(req, "sleep_phase", int'(sleep_phase), ph);
        chk(req, "cpu_clk_en", int'(cpu_clk_en), (m == 0) ? 1 : 0);
    endtask

    task automatic chk_e(input string req);
        chk(req, "energy", int'(energy), exp_e);
    endtask

    // One clock: drive at falling edge, sample just after the rising edge
    task automatic cyc(input logic tk, input logic ri, input logic rs, input logic wk);
        @(negedge clk);
        tick = tk; req_idle = ri; req_sleep = rs; wake = wk;
        @(posedge clk);
        #1;
        tick = 1'b0; req_idle = 1'b0; req_sleep = 1'b0; wake = 1'b0;
    endtask

    // n ticks charged at weight w
    task automatic ticks(input int n, input int w);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 1'b0);
            exp_e = (exp_e + w > EMAX) ? EMAX : exp_e + w;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not finish actual=1 expected=0");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk_state("R1", 0, 0, 0);
        chk("R1", "pwr_en", int'(pwr_en), 1);
        chk_e("R1");

        // R3 run to idle, with R5/R10 ignored requests and tickless cycle
        cyc(1'b0, 1'b1, 1'b0, 1'b0);
        chk_state("R3", 0, 1, 0);
        cyc(1'b0, 1'b0, 1'b1, 1'b1);
        chk_state("R10", 0, 1, 0);
        ticks(T_RI - 1, WR);
        chk_state("R3", 0, 1, 0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        chk_state("R5", 0, 1, 0);
        ticks(1, WR);
        chk_state("R3", 1, 0, 0);
        chk("R2", "pwr_en", int'(pwr_en), 1);
        chk_e("R8");

        // R6 idle: req_idle ignored, wake beats sleep
        cyc(1'b0, 1'b1, 1'b0, 1'b0);
        chk_state("R6", 1, 0, 0);
        cyc(1'b0, 1'b0, 1'b1, 1'b1);
        chk_state("R6", 1, 1, 0);
        ticks(T_IR - 1, WI);
        chk_state("R3", 1, 1, 0);
        ticks(1, WI);
        chk_state("R3", 0, 0, 0);
        chk_e("R8");

        // R6 run: wake ignored, sleep beats idle
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        chk_state("R6", 0, 0, 0);
        cyc(1'b0, 1'b1, 1'b1, 1'b0);
        chk_state("R6", 0, 1, 1);
        // R4 step sweep with a repeated sleep request (R5)
        for (int s = 0; s < 3; s++) begin
            for (int t = 0; t < T_ST; t++) begin
                chk_state("R4", 0, 1, 1 << s);
                if (s == 1 && t == 0) begin
                    cyc(1'b0, 1'b0, 1'b1, 1'b0);
                    chk_state("R5", 0, 1, 1 << s);
                end
                ticks(1, WR);
            end
        end
        chk_state("R4", 2, 0, 0);
        chk("R2", "pwr_en", int'(pwr_en), 0);
        chk_e("R8");

        // R6 sleep: only wake accepted
        cyc(1'b0, 1'b1, 1'b1, 1'b0);
        chk_state("R6", 2, 0, 0);
        ticks(5, WS);
        chk_e("R8");
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
        chk_e("R8");

        // R7 wake from sleep
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R7", "pwr_en", int'(pwr_en), 1);
        chk_state("R7", 2, 1, 0);
        ticks(T_SR - 1, WS);
        chk_state("R3", 2, 1, 0);
        ticks(1, WS);
        chk_state("R3", 0, 0, 0);
        chk_e("R8");

        // R4 sleep entry from idle, charged at idle weight
        cyc(1'b0, 1'b1, 1'b0, 1'b0);
        ticks(T_RI, WR);
        chk_state("R3", 1, 0, 0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        chk_state("R4", 1, 1, 1);
        ticks(3 * T_ST - 1, WI);
        chk_state("R4", 1, 1, 4);
        ticks(1, WI);
        chk_state("R4", 2, 0, 0);
        chk_e("R8");
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        ticks(T_SR, WS);
        chk_state("R3", 0, 0, 0);
        chk_e("R8");

        // R9 saturation sweep in run
        for (int i = 0; i < 140; i++) begin
            ticks(1, WR);
            chk_e("R9");
        end
        chk("R9", "energy_max", int'(energy), EMAX);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule